// File: doc/BRIEF.md
# Data Access Translation Gate

This block sits between the load/store unit and the translation lookaside array of a processor core. For every data access it decides, in a fixed order of precedence, whether the access goes straight through with its address unchanged, stops with an address error, or needs translation. When translation is needed it uses a lookup result supplied by the array in the same cycle (miss, multiple hit, or a single hit carrying permission flags, a physical page number and a page mask). From that result it either forms the physical address or reports one fault code.

The decision is registered: one cycle after a request, a valid strobe comes with exactly one of three outcome flags (pass-through, translated, fault), the physical address and the code. A multiple hit is flagged as a reset-class event. For every fault that comes from the translation path, the block records the full faulting address and loads address bits 31:10 into a staged page-table high register, whose low 10 bits are kept. Software can also write that register directly. The block also drives a combinational request telling the array whether to compare address-space identifiers.

Top module: `xlat_access_gate`

## Requirements
- R1: In privileged mode an address with bit 31 set passes through unchanged, unless it lies in 0xC0000000..0xDFFFFFFF. That window goes to the translation path.
- R2: In user mode an address with bit 31 set faults with code 1 (read) or code 2 (write). The only exception is 0xE0000000..0xE3FFFFFF, which passes through when `cfg_sq_lock` is 0.
- R3: When `cfg_xlat_en` is 0, every address that R1 and R2 do not settle passes through unchanged.
- R4: `asid_cmp` is 0 only when `cfg_single_vs` is 1 and `req_priv` is 1. Otherwise it is 1.
- R5: On the translation path a miss gives code 3 (read) or code 4 (write). A multiple hit gives code 8, raises `rsp_reset`, and wins over a miss.
- R6: A translated write faults with code 6 if, in privileged mode, the writable flag (`lk_flags[1]`) is clear. In user mode it faults with code 6 unless both the writable flag and the user flag (`lk_flags[2]`) are set.
- R7: A translated write that passes R6 but whose dirty flag (`lk_flags[0]`) is clear faults with code 7. A write failing both checks reports code 6.
- R8: A translated user read of an entry with a clear user flag faults with code 5. A privileged read ignores the user flag.
- R9: A translated access without fault returns (`lk_ppn` AND `lk_mask`) OR (address AND NOT `lk_mask`).
- R10: `rsp_valid` follows `req_valid` by one cycle. With it comes exactly one of `rsp_pass`, `rsp_ok` and `rsp_fault`. The code is 0 unless the outcome is a fault, and the address is 0 on a fault. All outcome outputs are 0 when `rsp_valid` is 0.
- R11: A fault with code 3 to 8 loads `fault_addr` with the request address, and loads `stage_hi[31:10]` with address bits 31:10 while keeping `stage_hi[9:0]`. Codes 1 and 2 change neither register.
- R12: `stage_hi_wr` loads `stage_hi` with `stage_hi_wdata`. If a fault capture from R11 happens in the same cycle, the capture takes precedence.
- R13: After reset all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | 32 | Virtual address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| cfg_xlat_en | input | 1 | Address translation enable |
| cfg_single_vs | input | 1 | Single virtual space mode |
| cfg_sq_lock | input | 1 | 1 blocks user access to the store-queue window |
| lk_miss | input | 1 | Lookup found no entry |
| lk_multi | input | 1 | Lookup found more than one entry |
| lk_flags | input | 3 | Hit flags {user, writable, dirty} |
| lk_ppn | input | 32 | Physical page base of the hit |
| lk_mask | input | 32 | Page mask of the hit, ones over page-number bits |
| asid_cmp | output | 1 | Request identifier comparison from the array |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_pass | output | 1 | Untranslated pass-through |
| rsp_ok | output | 1 | Translated without fault |
| rsp_fault | output | 1 | Fault reported |
| rsp_reset | output | 1 | Fault is reset-class (multiple hit) |
| rsp_code | output | 4 | Fault code, 0 if none |
| rsp_paddr | output | 32 | Physical address |
| fault_addr | output | 32 | Captured faulting address |
| stage_hi | output | 32 | Staged page-table high register |
| stage_hi_wr | input | 1 | Software write strobe for the staged high register |
| stage_hi_wdata | input | 32 | Software write data |

## Verification
The table of vectors walks each region boundary: just inside and just outside the privileged translated window, the store-queue window with both lock settings, and the first address above it. These separate range decoding errors from mode errors. The flag patterns cover every combination that matters for write protection and the dirty flag in both modes, which shows whether the precedence between protection and initial-write faults holds. Three page masks with non-trivial low bits show whether the physical address merges page bits and offset bits at the right boundary. Directed sequences then check that address errors leave the capture registers alone, that a fault overrides a software write in the same cycle, and that the identifier-compare request follows the mode bits.

// File: rtl/xag_pkg.sv
// Shared types for the data access translation gate.
// Assumes a 32-bit virtual address and three permission flags per entry.
package xag_pkg;

    // Fault codes; values are visible at the rsp_code port.
    typedef enum logic [3:0] {
        XC_NONE    = 4'd0,
        XC_ADDR_RD = 4'd1,
        XC_ADDR_WR = 4'd2,
        XC_MISS_RD = 4'd3,
        XC_MISS_WR = 4'd4,
        XC_PROT_RD = 4'd5,
        XC_PROT_WR = 4'd6,
        XC_INIT_WR = 4'd7,
        XC_MULTI   = 4'd8
    } xcode_e;

    // Outcome of the region decode.
    typedef enum logic [1:0] {
        RG_PASS     = 2'd0,
        RG_ADDR_ERR = 2'd1,
        RG_XLAT     = 2'd2
    } region_e;

    // Permission flags of a hit entry, msb first: user, writable, dirty.
    typedef struct packed {
        logic user;
        logic writable;
        logic dirty;
    } pte_flags_t;

    localparam int FLAG_W = $bits(pte_flags_t);
    localparam int CODE_W = $bits(xcode_e);

    // Top-bit patterns of the special windows.
    localparam logic [2:0] PRIV_XLAT_TOP3 = 3'b110;    // 0xC0000000..0xDFFFFFFF
    localparam logic [5:0] SQ_TOP6        = 6'b111000; // 0xE0000000..0xE3FFFFFF

endpackage

// File: rtl/xag_region.sv
// Region decode: sorts an access into pass-through, address error, or
// translation. It looks only at the top six address bits, the mode and the
// control bits. Assumes the windows are aligned to 2^(ADDR_W-6).
module xag_region
    import xag_pkg::*;
(
    input  logic [5:0] addr_top,
    input  logic       priv,
    input  logic       sq_lock,
    input  logic       xlat_en,
    output region_e    region
);

    logic high_half;
    logic in_priv_xlat;
    logic in_sq_open;

    assign high_half    = addr_top[5];
    assign in_priv_xlat = (addr_top[5:3] == PRIV_XLAT_TOP3);
    assign in_sq_open   = (addr_top == SQ_TOP6) && !sq_lock;

    // Apply the region rules in order of precedence.
    always_comb begin
        if (high_half && priv && !in_priv_xlat) begin
            region = RG_PASS;
        end else if (high_half && !priv) begin
            region = in_sq_open ? RG_PASS : RG_ADDR_ERR;
        end else if (!xlat_en) begin
            region = RG_PASS;
        end else begin
            region = RG_XLAT;
        end
    end

endmodule

// File: rtl/xag_perm.sv
// Lookup-result check: turns a miss, a multiple hit or a hit with flags
// into a fault code, or XC_NONE when the access may proceed.
// Assumes it is consulted only for accesses on the translation path.
module xag_perm
    import xag_pkg::*;
(
    input  logic       write,
    input  logic       priv,
    input  logic       miss,
    input  logic       multi,
    input  pte_flags_t flags,
    output xcode_e     code
);

    logic wr_denied;

    // Write permission depends on the mode.
    always_comb begin
        if (priv) begin
            wr_denied = !flags.writable;
        end else begin
            wr_denied = !(flags.writable && flags.user);
        end
    end

    // Precedence: multiple hit, miss, protection, then clean-page write.
    always_comb begin
        if (multi) begin
            code = XC_MULTI;
        end else if (miss) begin
            code = write ? XC_MISS_WR : XC_MISS_RD;
        end else if (write) begin
            if (wr_denied) begin
                code = XC_PROT_WR;
            end else if (!flags.dirty) begin
                code = XC_INIT_WR;
            end else begin
                code = XC_NONE;
            end
        end else if (!priv && !flags.user) begin
            code = XC_PROT_RD;
        end else begin
            code = XC_NONE;
        end
    end

endmodule

// File: rtl/xag_fault_regs.sv
// Fault capture registers: the faulting-address register and the staged
// page-table high register. A capture overrides a software write in the same
// cycle. Assumes cap_en is asserted only for translation-path faults.
module xag_fault_regs #(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              sw_wr,
    input  logic [ADDR_W-1:0] sw_data,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] stage_hi
);

    localparam int VPN_W = ADDR_W - KEEP_W;

    // Faulting address: loaded on every capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr <= '0;
        end else if (cap_en) begin
            fault_addr <= cap_addr;
        end
    end

    // Staged high register: page-number field on capture, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi <= '0;
        end else if (cap_en) begin
            stage_hi[ADDR_W-1:KEEP_W] <= cap_addr[ADDR_W-1:KEEP_W];
        end else if (sw_wr) begin
            stage_hi <= sw_data;
        end
    end

    p_capture_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> fault_addr == $past(cap_addr));

    p_capture_vpn_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> stage_hi[ADDR_W-1:KEEP_W] == $past(cap_addr[ADDR_W-1:KEEP_W]));

    p_keep_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> $stable(stage_hi[KEEP_W-1:0]));

    p_sw_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !cap_en) |=> stage_hi == $past(sw_data));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr && !cap_en) |=> ($stable(stage_hi) && $stable(fault_addr)));

    initial begin
        assert (VPN_W > 0) else $error("KEEP_W must be below ADDR_W");
    end

endmodule

// File: rtl/xlat_access_gate.sv
// Data access translation gate, top level. Combines the region decode and
// the lookup-result check, registers one outcome per request, and drives the
// fault capture registers. Assumes the lookup result belongs to the request
// presented in the same cycle.
module xlat_access_gate
    import xag_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEEP_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              cfg_xlat_en,
    input  logic              cfg_single_vs,
    input  logic              cfg_sq_lock,
    input  logic              lk_miss,
    input  logic              lk_multi,
    input  logic [FLAG_W-1:0] lk_flags,
    input  logic [ADDR_W-1:0] lk_ppn,
    input  logic [ADDR_W-1:0] lk_mask,
    output logic              asid_cmp,
    output logic              rsp_valid,
    output logic              rsp_pass,
    output logic              rsp_ok,
    output logic              rsp_fault,
    output logic              rsp_reset,
    output logic [CODE_W-1:0] rsp_code,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [ADDR_W-1:0] stage_hi,
    input  logic              stage_hi_wr,
    input  logic [ADDR_W-1:0] stage_hi_wdata
);

    region_e           region;
    xcode_e            perm_code;
    xcode_e            nxt_code;
    logic              nxt_pass;
    logic              nxt_ok;
    logic              nxt_fault;
    logic [ADDR_W-1:0] nxt_paddr;
    logic [ADDR_W-1:0] xlat_paddr;
    logic              tlb_fault;

    xag_region u_region (
        .addr_top (req_addr[ADDR_W-1 -: 6]),
        .priv     (req_priv),
        .sq_lock  (cfg_sq_lock),
        .xlat_en  (cfg_xlat_en),
        .region   (region)
    );

    xag_perm u_perm (
        .write (req_write),
        .priv  (req_priv),
        .miss  (lk_miss),
        .multi (lk_multi),
        .flags (pte_flags_t'(lk_flags)),
        .code  (perm_code)
    );

    // Identifier comparison is skipped only for privileged single-space access.
    assign asid_cmp = !(cfg_single_vs && req_priv);

    // Physical address merge: page bits from the entry, offset from the request.
    assign xlat_paddr = (lk_ppn & lk_mask) | (req_addr & ~lk_mask);

    // Select the outcome for this request.
    always_comb begin
        nxt_pass  = 1'b0;
        nxt_ok    = 1'b0;
        nxt_fault = 1'b0;
        nxt_code  = XC_NONE;
        nxt_paddr = '0;
        unique case (region)
            RG_PASS: begin
                nxt_pass  = 1'b1;
                nxt_paddr = req_addr;
            end
            RG_ADDR_ERR: begin
                nxt_fault = 1'b1;
                nxt_code  = req_write ? XC_ADDR_WR : XC_ADDR_RD;
            end
            default: begin
                if (perm_code != XC_NONE) begin
                    nxt_fault = 1'b1;
                    nxt_code  = perm_code;
                end else begin
                    nxt_ok    = 1'b1;
                    nxt_paddr = xlat_paddr;
                end
            end
        endcase
    end

    assign tlb_fault = req_valid && (region == RG_XLAT) && (perm_code != XC_NONE);

    // Result register: one strobe per request, outcome cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pass  <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_reset <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_pass  <= req_valid && nxt_pass;
            rsp_ok    <= req_valid && nxt_ok;
            rsp_fault <= req_valid && nxt_fault;
            rsp_reset <= req_valid && (nxt_code == XC_MULTI);
            rsp_code  <= req_valid ? nxt_code : XC_NONE;
            rsp_paddr <= req_valid ? nxt_paddr : '0;
        end
    end

    xag_fault_regs #(
        .ADDR_W (ADDR_W),
        .KEEP_W (KEEP_W)
    ) u_fault_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (tlb_fault),
        .cap_addr   (req_addr),
        .sw_wr      (stage_hi_wr),
        .sw_data    (stage_hi_wdata),
        .fault_addr (fault_addr),
        .stage_hi   (stage_hi)
    );

    p_valid_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_onehot_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_pass, rsp_ok, rsp_fault}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ({rsp_pass, rsp_ok, rsp_fault, rsp_reset} == 4'b0));

    p_code_only_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != '0) |-> rsp_fault);

    p_user_high_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && req_addr[ADDR_W-1] &&
         !(req_addr[ADDR_W-1 -: 6] == SQ_TOP6 && !cfg_sq_lock))
        |=> (rsp_fault && (rsp_code == XC_ADDR_RD || rsp_code == XC_ADDR_WR)));

    p_xlat_off_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_xlat_en && !req_addr[ADDR_W-1])
        |=> (rsp_pass && rsp_paddr == $past(req_addr)));

    p_prot_before_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv && req_write && cfg_xlat_en && !req_addr[ADDR_W-1] &&
         !lk_miss && !lk_multi && !lk_flags[1])
        |=> (rsp_code == XC_PROT_WR));

    p_reset_is_multi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_reset |-> (rsp_fault && rsp_code == XC_MULTI));

endmodule

// File: tb/test_xlat_access_gate.sv
module test_xlat_access_gate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_priv;
    logic [31:0] req_addr;
    logic        cfg_xlat_en, cfg_single_vs, cfg_sq_lock;
    logic        lk_miss, lk_multi;
    logic [2:0]  lk_flags;
    logic [31:0] lk_ppn, lk_mask;
    logic        asid_cmp, rsp_valid, rsp_pass, rsp_ok, rsp_fault, rsp_reset;
    logic [3:0]  rsp_code;
    logic [31:0] rsp_paddr, fault_addr, stage_hi;
    logic        stage_hi_wr;
    logic [31:0] stage_hi_wdata;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    xlat_access_gate i_xlat_access_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_priv(req_priv), .cfg_xlat_en(cfg_xlat_en),
        .cfg_single_vs(cfg_single_vs), .cfg_sq_lock(cfg_sq_lock),
        .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_flags(lk_flags),
        .lk_ppn(lk_ppn), .lk_mask(lk_mask), .asid_cmp(asid_cmp),
        .rsp_valid(rsp_valid), .rsp_pass(rsp_pass), .rsp_ok(rsp_ok),
        .rsp_fault(rsp_fault), .rsp_reset(rsp_reset), .rsp_code(rsp_code),
        .rsp_paddr(rsp_paddr), .fault_addr(fault_addr), .stage_hi(stage_hi),
        .stage_hi_wr(stage_hi_wr), .stage_hi_wdata(stage_hi_wdata)
    );

    // kind = {pass, ok, fault}; flags = {user, writable, dirty}
    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] addr;
        logic        wr, priv, xen, sq, miss, multi;
        logic [2:0]  flags;
        logic [31:0] ppn, mask;
        logic [2:0]  kind;
        logic [3:0]  code;
        logic [31:0] paddr;
    } vec_t;

    localparam logic [31:0] M4K = 32'hFFFFF000;
    localparam logic [31:0] M1M = 32'hFFF00000;
    localparam logic [31:0] M1K = 32'hFFFFFC00;
    localparam logic [31:0] PP  = 32'h0ABCD000;
    localparam logic [2:0]  KP  = 3'b100;
    localparam logic [2:0]  KO  = 3'b010;
    localparam logic [2:0]  KF  = 3'b001;
    localparam int NV = 22;

    localparam vec_t VECS [NV] = '{
        // R1 privileged high, outside translated window
        '{4'd1, 32'h80001000, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KP, 4'd0, 32'h80001000},
        '{4'd1, 32'hE0000010, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KP, 4'd0, 32'hE0000010},
        // R1 privileged translated window
        '{4'd1, 32'hC0001234, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KO, 4'd0, 32'h0ABCD234},
        // R2 user high region
        '{4'd2, 32'h80000000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KF, 4'd1, 32'h0},
        '{4'd2, 32'hA0000000, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KF, 4'd2, 32'h0},
        '{4'd2, 32'hE2000000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KP, 4'd0, 32'hE2000000},
        '{4'd2, 32'hE2000000, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 3'b111, PP, M4K, KF, 4'd2, 32'h0},
        '{4'd2, 32'hE4000000, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KF, 4'd1, 32'h0},
        // R3 translation disabled
        '{4'd3, 32'h00012345, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 3'b000, PP, M4K, KP, 4'd0, 32'h00012345},
        '{4'd3, 32'hC0000000, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 3'b000, PP, M4K, KP, 4'd0, 32'hC0000000},
        // R5 miss and multiple hit
        '{4'd5, 32'h00012345, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 3'b111, PP, M4K, KF, 4'd3, 32'h0},
        '{4'd5, 32'h00012345, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 3'b111, PP, M4K, KF, 4'd4, 32'h0},
        '{4'd5, 32'h00012345, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 3'b111, PP, M4K, KF, 4'd8, 32'h0},
        // R6 write protection
        '{4'd6, 32'h00012345, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b001, PP, M4K, KF, 4'd6, 32'h0},
        '{4'd6, 32'h00012345, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b011, PP, M4K, KF, 4'd6, 32'h0},
        '{4'd6, 32'h00012345, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b111, PP, M4K, KO, 4'd0, 32'h0ABCD345},
        // R7 clean page write, and protection taking precedence
        '{4'd7, 32'h00012345, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b010, PP, M4K, KF, 4'd7, 32'h0},
        '{4'd7, 32'h00012345, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b000, PP, M4K, KF, 4'd6, 32'h0},
        // R8 read protection
        '{4'd8, 32'h00012345, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 3'b011, PP, M4K, KF, 4'd5, 32'h0},
        '{4'd8, 32'h00012345, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b000, PP, M4K, KO, 4'd0, 32'h0ABCD345},
        // R9 page sizes
        '{4'd9, 32'h00ABCDEF, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b111, 32'h0C312345, M1M, KO, 4'd0, 32'h0C3BCDEF},
        '{4'd9, 32'h00001FFF, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 3'b111, 32'h12345400, M1K, KO, 4'd0, 32'h123457FF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_addr = '0; req_write = 0; req_priv = 0;
        cfg_xlat_en = 0; cfg_single_vs = 0; cfg_sq_lock = 0;
        lk_miss = 0; lk_multi = 0; lk_flags = '0; lk_ppn = '0; lk_mask = '0;
        stage_hi_wr = 0; stage_hi_wdata = '0;
    endtask

    // Present one request for a cycle; results are read at the next negedge.
    task automatic do_req(input logic [31:0] a, input logic w, input logic p,
                          input logic xen, input logic miss, input logic hiwr,
                          input logic [31:0] hidata);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = w; req_priv = p;
        cfg_xlat_en = xen; cfg_sq_lock = 0; lk_miss = miss; lk_multi = 0;
        lk_flags = 3'b111; lk_ppn = PP; lk_mask = M4K;
        stage_hi_wr = hiwr; stage_hi_wdata = hidata;
        @(negedge clk);
        req_valid = 0; stage_hi_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R13 reset state
        chk("R13 reset outputs",
            {27'd0, rsp_valid, rsp_pass, rsp_ok, rsp_fault, rsp_reset, rsp_code, rsp_paddr}, 64'd0);
        chk("R13 reset capture regs", {fault_addr, stage_hi}, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = 1; req_addr = VECS[i].addr; req_write = VECS[i].wr;
            req_priv = VECS[i].priv; cfg_xlat_en = VECS[i].xen; cfg_single_vs = 0;
            cfg_sq_lock = VECS[i].sq; lk_miss = VECS[i].miss; lk_multi = VECS[i].multi;
            lk_flags = VECS[i].flags; lk_ppn = VECS[i].ppn; lk_mask = VECS[i].mask;
            @(negedge clk);
            req_valid = 0;
            chk($sformatf("R%0d vector %0d (R10 strobe)", VECS[i].req, i),
                {20'd0, rsp_valid, rsp_pass, rsp_ok, rsp_fault, rsp_reset, rsp_code, rsp_paddr},
                {20'd0, 1'b1, VECS[i].kind, (VECS[i].code == 4'd8), VECS[i].code, VECS[i].paddr});
        end
        @(negedge clk);
        // R10 idle after request
        chk("R10 idle quiet", {59'd0, rsp_valid, rsp_pass, rsp_ok, rsp_fault, rsp_reset}, 64'd0);

        // R4 identifier compare request
        idle_inputs();
        req_priv = 1; cfg_single_vs = 1; #1;
        chk("R4 priv single", {63'd0, asid_cmp}, 64'd0);
        req_priv = 0; #1;
        chk("R4 user single", {63'd0, asid_cmp}, 64'd1);
        req_priv = 1; cfg_single_vs = 0; #1;
        chk("R4 priv multi-space", {63'd0, asid_cmp}, 64'd1);
        cfg_single_vs = 0;

        // R12 software write of staged register
        do_req(32'h0, 0, 1, 0, 0, 1, 32'h000003A5);
        chk("R12 sw write", {32'd0, stage_hi}, {32'd0, 32'h000003A5});

        // R11 miss captures address, keeps low bits
        do_req(32'h12345678, 0, 0, 1, 1, 0, 32'h0);
        chk("R11 capture", {fault_addr, stage_hi}, {32'h12345678, 32'h123457A5});

        // R11 address error leaves capture regs alone
        do_req(32'h90000000, 0, 0, 1, 0, 0, 32'h0);
        chk("R11 addr err no capture", {fault_addr, stage_hi}, {32'h12345678, 32'h123457A5});

        // R12 capture wins over simultaneous software write
        do_req(32'h00000C00, 1, 0, 1, 1, 1, 32'hFFFFFFFF);
        chk("R12 capture precedence", {fault_addr, stage_hi}, {32'h00000C00, 32'h00000FA5});

        // R12 plain software write afterwards
        do_req(32'h0, 0, 1, 0, 0, 1, 32'hDEADBEEF);
        chk("R12 sw write full", {fault_addr, stage_hi}, {32'h00000C00, 32'hDEADBEEF});

        // R13 reset clears captured state again
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R13 reset reapplied", {fault_addr, stage_hi}, 64'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule